// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block gathers up to 21 peripheral interrupt requests and turns them into two processor interrupt lines: a normal line and a fast line. Each request input passes through a synchronizer. A rising edge on the synchronized request sets that source's pending bit. Software chooses which line each source drives, can hold off single sources or all of them, and acknowledges a source by writing a one to its pending bit.

A dispatch routine reads a vector register. That register returns the number of the most urgent serviceable source already multiplied by four, so it can index a word-sized jump table directly. Priority is fixed: the lowest source number wins. A reserved code means that nothing is waiting.

All registers sit on a small word-addressed bus with separate read and write strobes. Read data comes back one cycle after the read strobe.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset the routing register reads 0, the pending register reads 0, the mask register reads 0x3FFFFF (all 21 source bits and the global bit 21 set), the vector register reads 84, and both interrupt outputs are low.
- R2: A low-to-high transition on `src_req[i]` sets pending bit i once the synchronizer has passed it. A request held high does not set the bit again after it has been cleared.
- R3: A bus write to the pending register clears each pending bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: If a rising edge and a clearing write reach the same pending bit in the same cycle, the bit ends up set.
- R5: Routing bit i at 0 sends source i to `irq_o`, and routing bit i at 1 sends it to `fiq_o`.
- R6: Mask bit i at 1 keeps source i off both outputs and out of the vector register. Its pending bit is still set and still reads back.
- R7: Mask bit 21 at 1 forces both outputs low and makes the vector register read the reserved code, whatever is pending.
- R8: The vector register reads 4 × (lowest index among sources that are pending and not masked).
- R9: When no source is pending and unmasked, the vector register reads 84 (21 × 4).
- R10: Register offsets are routing 0x0, pending 0x4, mask 0x8 and vector 0xC. An access whose address bits [1:0] are not 00 is ignored. The vector register is read-only. Bits above the implemented width ignore writes and read back as 0. `bus_rdata` carries the selected value from the cycle after `bus_rd`.
- R11: `irq_o` and `fiq_o` are registered levels. Each stays high for as long as a qualifying source remains pending, and it drops one cycle after the last such pending bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 21 | Asynchronous interrupt request lines, one per source |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |

## Verification
Internal faults show up at the ports in specific ways:
- A pending bit that is lost, stuck or set twice shows up in the pending readback on the next read. It also changes the interrupt outputs one cycle after the pending register updates.
- A wrong priority order or a masking fault produces a wrong vector code at the very next read.
- A routing fault raises the wrong one of the two lines.
- A broken global mask leaves a line high in the cycle after the mask bit is set.

Edge detection and the set-versus-clear race appear as a pending bit that does or does not survive a clearing write issued in the exact cycle of the edge.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    localparam int unsigned SRC_N  = 21;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 4;

    typedef enum logic [1:0] {
        SEL_ROUTE = 2'd0,
        SEL_PEND  = 2'd1,
        SEL_MASK  = 2'd2,
        SEL_VEC   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        logic     rd;
        logic     hit;
        reg_sel_e sel;
    } bus_dec_t;

    typedef struct packed {
        logic norm;
        logic fast;
    } line_pair_t;

    function automatic bus_dec_t decode_bus(input logic wr, input logic rd,
                                            input logic [ADDR_W-1:0] addr);
        bus_dec_t d;
        d.hit = (addr[1:0] == 2'b00);
        d.wr  = wr & d.hit;
        d.rd  = rd & d.hit;
        d.sel = reg_sel_e'(addr[3:2]);
        return d;
    endfunction

endpackage

// File: rtl/ivc_req_sync.sv
module ivc_req_sync #(
    parameter int unsigned WIDTH  = 21,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] req_i,
    output logic [WIDTH-1:0] rise_o
);

    logic [WIDTH-1:0] stg_q [STAGES];
    logic [WIDTH-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
            last_q <= '0;
        end else begin
            stg_q[0] <= req_i;
            for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
            last_q <= stg_q[STAGES-1];
        end
    end

    assign rise_o = stg_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/ivc_pend_bank.sv
module ivc_pend_bank #(
    parameter int unsigned WIDTH = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] pend_o
);

    logic [WIDTH-1:0] pend_q;

    // set has precedence over a simultaneous clear
    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~clr_i) | set_i;
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/ivc_prio_enc.sv
module ivc_prio_enc #(
    parameter int unsigned WIDTH = 21,
    parameter int unsigned IDX_W = 5
) (
    input  logic [WIDTH-1:0] req_i,
    output logic [IDX_W-1:0] idx_o
);

    // lowest index wins; WIDTH itself is the idle code
    always_comb begin
        idx_o = IDX_W'(WIDTH);
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
    end

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import ivc_pkg::*;
#(
    parameter int unsigned NUM_SRC     = SRC_N,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_o,
    output logic               fiq_o
);

    localparam int unsigned IDX_W     = $clog2(NUM_SRC + 1);
    localparam int unsigned GMASK_BIT = NUM_SRC;
    localparam int unsigned MASK_W    = NUM_SRC + 1;

    bus_dec_t           dec;
    logic [NUM_SRC-1:0] route_q;
    logic [MASK_W-1:0]  mask_q;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] pend_clr;
    logic [NUM_SRC-1:0] act;
    logic [IDX_W-1:0]   win_idx;
    logic [DATA_W-1:0]  vec_word;
    logic [DATA_W-1:0]  rdata_q;
    line_pair_t         lines_d, lines_q;
    logic               unused_wdata;

    assign dec = decode_bus(bus_wr, bus_rd, bus_addr);
    assign unused_wdata = ^bus_wdata[DATA_W-1:MASK_W];

    ivc_req_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .req_i  (src_req),
        .rise_o (rise)
    );

    assign pend_clr = (dec.wr && dec.sel == SEL_PEND) ? bus_wdata[NUM_SRC-1:0] : '0;

    ivc_pend_bank #(.WIDTH(NUM_SRC)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .set_i  (rise),
        .clr_i  (pend_clr),
        .pend_o (pend_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            route_q <= '0;
            mask_q  <= '1;
        end else if (dec.wr) begin
            if (dec.sel == SEL_ROUTE) route_q <= bus_wdata[NUM_SRC-1:0];
            if (dec.sel == SEL_MASK)  mask_q  <= bus_wdata[MASK_W-1:0];
        end
    end

    assign act = pend_q & ~mask_q[NUM_SRC-1:0] & {NUM_SRC{~mask_q[GMASK_BIT]}};

    ivc_prio_enc #(.WIDTH(NUM_SRC), .IDX_W(IDX_W)) u_prio (
        .req_i (act),
        .idx_o (win_idx)
    );

    assign vec_word = DATA_W'(win_idx) << 2;

    always_comb begin
        lines_d.norm = |(act & ~route_q);
        lines_d.fast = |(act & route_q);
    end

    always_ff @(posedge clk) begin
        if (rst) lines_q <= '0;
        else     lines_q <= lines_d;
    end

    assign irq_o = lines_q.norm;
    assign fiq_o = lines_q.fast;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (dec.rd) begin
            case (dec.sel)
                SEL_ROUTE: rdata_q <= DATA_W'(route_q);
                SEL_PEND:  rdata_q <= DATA_W'(pend_q);
                SEL_MASK:  rdata_q <= DATA_W'(mask_q);
                SEL_VEC:   rdata_q <= vec_word;
                default:   rdata_q <= '0;
            endcase
        end
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/ivc_chk.sv
module ivc_chk #(
    parameter int unsigned NUM_SRC = 21,
    parameter int unsigned IDX_W   = 5
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] pend_q,
    input logic [NUM_SRC-1:0] rise,
    input logic [NUM_SRC-1:0] pend_clr,
    input logic [NUM_SRC-1:0] act,
    input logic [NUM_SRC-1:0] route_q,
    input logic [NUM_SRC:0]   mask_q,
    input logic [IDX_W-1:0]   win_idx,
    input logic               irq_o,
    input logic               fiq_o
);

    logic [NUM_SRC-1:0] below_win;
    assign below_win = (NUM_SRC'(1) << win_idx) - NUM_SRC'(1);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_q == '1 && pend_q == '0 && route_q == '0));

    // R3
    clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
        ((pend_clr & ~rise) != '0) |=> ((pend_q & $past(pend_clr & ~rise)) == '0));

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (rise != '0) |=> ((pend_q & $past(rise)) == $past(rise)));

    // R7
    global_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        mask_q[NUM_SRC] |=> (!irq_o && !fiq_o));

    // R8
    winner_low_chk: assert property (@(posedge clk) disable iff (rst)
        (act != '0) |-> (win_idx < IDX_W'(NUM_SRC) && act[win_idx] && (act & below_win) == '0));

    // R9
    idle_code_chk: assert property (@(posedge clk) disable iff (rst)
        (act == '0) |-> (win_idx == IDX_W'(NUM_SRC)));

    // R11
    line_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_o || fiq_o) |-> ($past(pend_q) != '0));

endmodule

bind irq_vec_ctrl ivc_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pend_q   (pend_q),
    .rise     (rise),
    .pend_clr (pend_clr),
    .act      (act),
    .route_q  (route_q),
    .mask_q   (mask_q),
    .win_idx  (win_idx),
    .irq_o    (irq_o),
    .fiq_o    (fiq_o)
);

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb;
    import ivc_pkg::*;

    localparam int N = 21;
    localparam logic [3:0] A_ROUTE = 4'h0;
    localparam logic [3:0] A_PEND  = 4'h4;
    localparam logic [3:0] A_MASK  = 4'h8;
    localparam logic [3:0] A_VEC   = 4'hC;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  src_req = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_o, fiq_o;

    int total = 0;
    int bad = 0;
    logic done = 1'b0;

    logic [N-1:0]  m_route = '0;
    logic [N:0]    m_mask  = '1;
    logic [N-1:0]  m_pend  = '0;

    always #10 clk = ~clk;

    irq_vec_ctrl u_dut (
        .clk(clk), .rst(rst), .src_req(src_req),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=0x%08h exp=0x%08h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic raise(input logic [N-1:0] bits);
        logic [N-1:0] fresh;
        fresh = bits & ~src_req;
        src_req = src_req | bits;
        settle();
        m_pend = m_pend | fresh;
    endtask

    task automatic lower(input logic [N-1:0] bits);
        src_req = src_req & ~bits;
        settle();
    endtask

    function automatic logic [N-1:0] exp_act();
        return m_pend & ~m_mask[N-1:0] & {N{~m_mask[N]}};
    endfunction

    function automatic logic [31:0] exp_vec();
        logic [N-1:0] a;
        int idx;
        a = exp_act();
        idx = N;
        for (int i = N - 1; i >= 0; i--) if (a[i]) idx = i;
        return 32'(idx) << 2;
    endfunction

    task automatic check_all(input string tag);
        logic [31:0] d;
        chk({tag, " irq"}, 32'(irq_o), 32'(|(exp_act() & ~m_route)));
        chk({tag, " fiq"}, 32'(fiq_o), 32'(|(exp_act() & m_route)));
        bus_read(A_PEND, d);
        chk({tag, " pend"}, d, 32'(m_pend));
        bus_read(A_VEC, d);
        chk({tag, " vec"}, d, exp_vec());
    endtask

    task automatic wmask(input logic [N:0] v);
        bus_write(A_MASK, 32'(v));
        m_mask = v;
        settle();
    endtask

    task automatic wroute(input logic [N-1:0] v);
        bus_write(A_ROUTE, 32'(v));
        m_route = v;
        settle();
    endtask

    task automatic wclear(input logic [N-1:0] v);
        bus_write(A_PEND, 32'(v));
        m_pend = m_pend & ~v;
        settle();
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got=0x%08h exp=0x%08h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", 32'(irq_o), 0);
        chk("R1 fiq", 32'(fiq_o), 0);
        bus_read(A_ROUTE, d); chk("R1 route", d, 0);
        bus_read(A_PEND, d);  chk("R1 pend", d, 0);
        bus_read(A_MASK, d);  chk("R1 mask", d, 32'h003F_FFFF);
        bus_read(A_VEC, d);   chk("R1 R9 vec", d, 84);

        // R10 width, read-only vector, misaligned access
        bus_write(A_ROUTE, 32'hFFFF_FFFF);
        bus_read(A_ROUTE, d); chk("R10 route width", d, 32'h001F_FFFF);
        bus_write(A_ROUTE, 32'h0);
        bus_write(A_VEC, 32'h0);
        bus_read(A_VEC, d); chk("R10 vec read-only", d, 84);
        bus_write(4'h9, 32'h0);
        bus_read(A_MASK, d); chk("R10 misaligned ignored", d, 32'h003F_FFFF);

        wmask('0);

        // R2 edge sets pending, R11 level output
        raise(N'(1) << 5);
        check_all("R2 src5");
        repeat (6) @(negedge clk);
        chk("R11 irq held", 32'(irq_o), 1);
        // R3 zero write no effect
        bus_write(A_PEND, 32'h0);
        bus_read(A_PEND, d); chk("R3 zero write", d, 32'h20);
        // R3 one write clears; R11 drop
        bus_write(A_PEND, 32'h20);
        m_pend = '0;
        @(negedge clk);
        chk("R11 irq drop", 32'(irq_o), 0);
        settle();
        bus_read(A_PEND, d); chk("R2 held high no reset", d, 0);
        lower(N'(1) << 5);

        // R8 priority, R6 masking, R9 idle
        raise((N'(1) << 12) | (N'(1) << 7));
        check_all("R8 pair");
        wmask((N + 1)'(1) << 7);
        check_all("R6 R8 mask7");
        wmask(((N + 1)'(1) << 7) | ((N + 1)'(1) << 12));
        check_all("R6 R9 both masked");
        wmask('0);
        wclear('1);
        lower('1);

        // R5 routing
        wroute(N'(1) << 3);
        raise(N'(1) << 3);
        check_all("R5 fast only");
        raise(N'(1) << 9);
        check_all("R5 both lines");

        // R7 global mask
        wmask((N + 1)'(1) << N);
        check_all("R7 global");
        wmask('0);
        check_all("R7 unmask");
        wclear('1);
        lower('1);
        wroute('0);

        // R4 set wins over clear in the same cycle
        @(negedge clk);
        src_req[14] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_write(A_PEND, 32'(1) << 14);
        m_pend = m_pend | (N'(1) << 14);
        bus_read(A_PEND, d); chk("R4 set wins", d, 32'(m_pend));
        settle();
        wclear('1);
        lower('1);

        // random mix: R2 R3 R5 R6 R7 R8 R11
        for (int it = 0; it < 150; it++) begin
            logic [N-1:0] rq, cl, rt;
            logic [N:0] mk;
            rt = N'($urandom);
            mk = (N + 1)'($urandom & $urandom);
            mk[N] = ($urandom_range(0, 3) == 0);
            wroute(rt);
            wmask(mk);
            rq = N'($urandom & $urandom);
            raise(rq);
            check_all("R2 R5 R6 R7 R8 rand");
            cl = N'($urandom);
            wclear(cl);
            check_all("R3 R11 rand clear");
            lower('1);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule